// File: doc/BRIEF.md
# Transmit Pin Ownership Arbiter

This block shares one bidirectional pad between a general-purpose port bit and a serial transmitter. It holds the port's data latch, the direction bit and a wired-OR mode bit. From the transmitter it takes an enable flag, a busy flag and the serial data bit. It drives the pad's output value and output enable, and it returns the value software sees when it reads the port bit.

The transmitter holds the pin while its enable is set. It keeps the pin after the enable clears for as long as a character is still being shifted out. While the transmitter holds the pin, port writes are still stored, but they reach the pad only when the pin returns to the port.

The read-back source depends on the direction bit, even when that bit has no effect on the pad. In wired-OR mode the high-side drive is removed, so a driven 1 leaves the pad floating and it relies on an external pull-up.

All pins are plain control and status signals. No data stream crosses the block's edge, so there is no valid/ready handshake and no back-pressure.

Top module: `txpin_arbiter`

## Requirements
- R1: After reset the port latch is 0, the direction bit is 0 (input), wired-OR mode is 0 and the transmitter does not own the pin, so pad_oe is 0.
- R2: The transmitter takes the pin on the first clock edge at which tx_en is sampled 1, and it keeps the pin while tx_en stays 1.
- R3: While the transmitter owns the pin and wired-OR mode is 0, pad_oe is 1 and pad_out equals tx_data, whatever the direction bit says.
- R4: A port write while the transmitter owns the pin does not change the pad, but the written value is stored in the port latch.
- R5: After tx_en clears, the transmitter keeps the pin while tx_busy is 1. The pin returns to the port on the clock edge at which tx_en=0 and tx_busy=0 are sampled. From that edge on, the latch value drives the pad if the direction bit is 1.
- R6: tx_busy=1 with tx_en=0 does not give the pin to a transmitter that does not already own it.
- R7: With the direction bit at 0, rd_data returns the level on the pad, including the level the transmitter is driving.
- R8: With the direction bit at 1, rd_data returns the port latch, even while the transmitter drives a different level on the pad.
- R9: With wired-OR mode at 1, the pad is never driven high. A driven 0 gives pad_oe=1 and pad_out=0. A driven 1 gives pad_oe=0, so the pad floats. This applies to both the port and the transmitter as source.
- R10: With the direction bit at 0 and no transmitter ownership, pad_oe is 0 for either value of the wired-OR mode bit, so the pad reads as an input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| port_wr | input | 1 | Strobe: load port latch from port_wdata |
| port_wdata | input | 1 | Port latch write value |
| dir_wr | input | 1 | Strobe: load direction bit from dir_wdata |
| dir_wdata | input | 1 | Direction write value (1 = output) |
| wom_wr | input | 1 | Strobe: load wired-OR mode bit from wom_wdata |
| wom_wdata | input | 1 | Wired-OR mode write value (1 = open drain) |
| tx_en | input | 1 | Transmitter enable |
| tx_busy | input | 1 | Transmitter still shifting a character |
| tx_data | input | 1 | Transmitter serial output bit |
| pad_in | input | 1 | Level sensed on the pad |
| pad_out | output | 1 | Value driven to the pad |
| pad_oe | output | 1 | Pad output enable |
| rd_data | output | 1 | Port bit read-back value |

## Verification
The pin is passed from the port to the transmitter and back with the latch and the transmitter data set to opposite levels. This shows which source reaches the pad in each cycle, and it shows the exact edge on which the transmitter takes and releases the pin. The release is tried with tx_busy held after the enable clears and also with tx_busy raised on an idle port, which separates "keep the pin" from "take the pin". Read-back is compared with each direction setting while the pad and the latch disagree, which shows where each value comes from. The wired-OR cases drive 0 and 1 from each source and from an external driver, which separates open-drain output behaviour from input behaviour.

// File: rtl/txpin_pkg.sv
package txpin_pkg;
  typedef enum logic {
    OWN_PORT = 1'b0,
    OWN_TX   = 1'b1
  } owner_e;

  localparam logic RST_LATCH = 1'b0;
  localparam logic RST_DIR   = 1'b0;
  localparam logic RST_WOM   = 1'b0;
endpackage

// File: rtl/txpin_regs.sv
module txpin_regs
  import txpin_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic port_wr,
  input  logic port_wdata,
  input  logic dir_wr,
  input  logic dir_wdata,
  input  logic wom_wr,
  input  logic wom_wdata,
  output logic latch_q,
  output logic dir_q,
  output logic wom_q
);
  // The latch is written whoever owns the pin; ownership only gates the pad.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= RST_LATCH;
      dir_q   <= RST_DIR;
      wom_q   <= RST_WOM;
    end else begin
      if (port_wr) latch_q <= port_wdata;
      if (dir_wr)  dir_q   <= dir_wdata;
      if (wom_wr)  wom_q   <= wom_wdata;
    end
  end
endmodule

// File: rtl/txpin_owner.sv
module txpin_owner
  import txpin_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   tx_en,
  input  logic   tx_busy,
  output owner_e owner_q
);
  owner_e owner_d;

  always_comb begin
    owner_d = owner_q;
    unique case (owner_q)
      OWN_PORT: if (tx_en) owner_d = OWN_TX;
      OWN_TX:   if (!tx_en && !tx_busy) owner_d = OWN_PORT;
      default:  owner_d = OWN_PORT;
    endcase
  end

  // The register feeds the output enable, so a change of owner never glitches it.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) owner_q <= OWN_PORT;
    else        owner_q <= owner_d;
  end
endmodule

// File: rtl/txpin_drive.sv
module txpin_drive
  import txpin_pkg::*;
(
  input  owner_e owner,
  input  logic   tx_data,
  input  logic   latch,
  input  logic   dir,
  input  logic   wom,
  output logic   pad_out,
  output logic   pad_oe
);
  logic src_val;
  logic src_en;

  always_comb begin
    src_val = (owner == OWN_TX) ? tx_data : latch;
    src_en  = (owner == OWN_TX) | dir;
    // Open drain: drop the high-side drive and float the pad for a 1.
    pad_oe  = src_en & (~wom | ~src_val);
    pad_out = wom ? 1'b0 : src_val;
  end
endmodule

// File: rtl/txpin_readback.sv
module txpin_readback (
  input  logic dir,
  input  logic latch,
  input  logic pad_in,
  output logic rd_data
);
  assign rd_data = dir ? latch : pad_in;
endmodule

// File: rtl/txpin_arbiter.sv
module txpin_arbiter
  import txpin_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic port_wr,
  input  logic port_wdata,
  input  logic dir_wr,
  input  logic dir_wdata,
  input  logic wom_wr,
  input  logic wom_wdata,
  input  logic tx_en,
  input  logic tx_busy,
  input  logic tx_data,
  input  logic pad_in,
  output logic pad_out,
  output logic pad_oe,
  output logic rd_data
);
  logic   latch_q;
  logic   dir_q;
  logic   wom_q;
  owner_e owner_q;

  txpin_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .port_wr    (port_wr),
    .port_wdata (port_wdata),
    .dir_wr     (dir_wr),
    .dir_wdata  (dir_wdata),
    .wom_wr     (wom_wr),
    .wom_wdata  (wom_wdata),
    .latch_q    (latch_q),
    .dir_q      (dir_q),
    .wom_q      (wom_q)
  );

  txpin_owner u_owner (
    .clk     (clk),
    .rst_n   (rst_n),
    .tx_en   (tx_en),
    .tx_busy (tx_busy),
    .owner_q (owner_q)
  );

  txpin_drive u_drive (
    .owner   (owner_q),
    .tx_data (tx_data),
    .latch   (latch_q),
    .dir     (dir_q),
    .wom     (wom_q),
    .pad_out (pad_out),
    .pad_oe  (pad_oe)
  );

  txpin_readback u_rb (
    .dir     (dir_q),
    .latch   (latch_q),
    .pad_in  (pad_in),
    .rd_data (rd_data)
  );
endmodule

// File: rtl/txpin_arbiter_chk.sv
module txpin_arbiter_chk
  import txpin_pkg::*;
(
  input logic   clk,
  input logic   rst_n,
  input logic   port_wr,
  input logic   port_wdata,
  input logic   tx_en,
  input logic   tx_busy,
  input logic   tx_data,
  input logic   pad_in,
  input logic   pad_out,
  input logic   pad_oe,
  input logic   rd_data,
  input owner_e owner_q,
  input logic   latch_q,
  input logic   dir_q,
  input logic   wom_q
);
  assert_take_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_en |=> (owner_q == OWN_TX));

  assert_tx_drives_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (owner_q == OWN_TX && !wom_q) |-> (pad_oe && pad_out == tx_data));

  assert_shadow_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (owner_q == OWN_TX && port_wr) |=> (latch_q == $past(port_wdata)));

  assert_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (owner_q == OWN_TX && !tx_en && !tx_busy) |=> (owner_q == OWN_PORT));

  assert_busy_no_take_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (owner_q == OWN_PORT && !tx_en) |=> (owner_q == OWN_PORT));

  assert_read_pin_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !dir_q |-> (rd_data == pad_in));

  assert_no_high_drive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wom_q |-> !(pad_oe && pad_out));

  assert_input_float_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (owner_q == OWN_PORT && !dir_q) |-> !pad_oe);
endmodule

bind txpin_arbiter txpin_arbiter_chk i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .port_wr    (port_wr),
  .port_wdata (port_wdata),
  .tx_en      (tx_en),
  .tx_busy    (tx_busy),
  .tx_data    (tx_data),
  .pad_in     (pad_in),
  .pad_out    (pad_out),
  .pad_oe     (pad_oe),
  .rd_data    (rd_data),
  .owner_q    (owner_q),
  .latch_q    (latch_q),
  .dir_q      (dir_q),
  .wom_q      (wom_q)
);

// File: tb/test_txpin_arbiter.sv
module test_txpin_arbiter;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic port_wr = 0, port_wdata = 0, dir_wr = 0, dir_wdata = 0;
  logic wom_wr = 0, wom_wdata = 0;
  logic tx_en = 0, tx_busy = 0, tx_data = 0;
  logic ext_en = 0, ext_val = 0;
  logic pad_out, pad_oe, rd_data;
  wire  pad;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  assign pad = pad_oe ? pad_out : 1'bz;
  assign pad = ext_en ? ext_val : 1'bz;
  pullup (pad);

  txpin_arbiter i_txpin_arbiter (
    .clk(clk), .rst_n(rst_n),
    .port_wr(port_wr), .port_wdata(port_wdata),
    .dir_wr(dir_wr), .dir_wdata(dir_wdata),
    .wom_wr(wom_wr), .wom_wdata(wom_wdata),
    .tx_en(tx_en), .tx_busy(tx_busy), .tx_data(tx_data),
    .pad_in(pad), .pad_out(pad_out), .pad_oe(pad_oe), .rd_data(rd_data)
  );

  task automatic check(input string req, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic wr_port(input logic v);
    port_wr = 1; port_wdata = v; tick(); port_wr = 0;
  endtask

  task automatic wr_dir(input logic v);
    dir_wr = 1; dir_wdata = v; tick(); dir_wr = 0;
  endtask

  task automatic wr_wom(input logic v);
    wom_wr = 1; wom_wdata = v; tick(); wom_wr = 0;
  endtask

  task automatic t_reset();
    check("R1", "pad_oe after reset", pad_oe, 1'b0);
    check("R1", "pad pulled up", pad, 1'b1);
    check("R1", "rd_data reads pin (dir 0)", rd_data, 1'b1);
  endtask

  task automatic t_port_out();
    wr_port(0);
    wr_dir(1);
    check("R8", "pad from latch 0", pad, 1'b0);
    check("R8", "rd_data latch 0", rd_data, 1'b0);
    wr_port(1);
    check("R8", "pad from latch 1", pad, 1'b1);
    check("R8", "rd_data latch 1", rd_data, 1'b1);
  endtask

  task automatic t_take();
    tx_data = 0; tx_en = 1; #1;
    check("R2", "pad before take edge", pad, 1'b1);
    tick();
    check("R2", "pad after take edge", pad, 1'b0);
    check("R3", "pad_oe while owned", pad_oe, 1'b1);
    check("R8", "rd_data latch while pin 0", rd_data, 1'b1);
    tx_data = 1; #1;
    check("R3", "pad follows tx_data 1", pad, 1'b1);
    tx_data = 0; #1;
    check("R3", "pad follows tx_data 0", pad, 1'b0);
    wr_dir(0);
    check("R3", "pad_oe with dir 0", pad_oe, 1'b1);
    check("R7", "rd_data is pin 0", rd_data, 1'b0);
    tx_data = 1; #1;
    check("R7", "rd_data is pin 1", rd_data, 1'b1);
    repeat (3) tick();
    check("R2", "still owner with tx_en held", pad_oe, 1'b1);
  endtask

  task automatic t_shadow();
    tx_data = 1;
    wr_port(0);
    check("R4", "pad unaffected by write", pad, 1'b1);
    wr_dir(1);
    check("R4", "stored latch readable", rd_data, 1'b0);
    check("R4", "pad still tx", pad, 1'b1);
  endtask

  task automatic t_release();
    tx_en = 0; tx_busy = 1; tx_data = 1;
    repeat (4) tick();
    check("R5", "owned while busy", pad, 1'b1);
    tx_busy = 0; #1;
    check("R5", "owned until release edge", pad, 1'b1);
    tick();
    check("R5", "latch drives after release", pad, 1'b0);
    check("R5", "pad_oe after release", pad_oe, 1'b1);
  endtask

  task automatic t_busy_only();
    wr_dir(0);
    tx_busy = 1; tx_data = 0;
    repeat (3) tick();
    check("R6", "busy alone leaves pad_oe 0", pad_oe, 1'b0);
    check("R6", "pad pulled up", pad, 1'b1);
    tx_busy = 0;
    tick();
  endtask

  task automatic t_wom();
    wr_wom(1);
    wr_dir(1);
    wr_port(1);
    check("R9", "port 1 floats", pad_oe, 1'b0);
    check("R9", "pad pulled up", pad, 1'b1);
    wr_port(0);
    check("R9", "port 0 drives", pad_oe, 1'b1);
    check("R9", "pad low", pad, 1'b0);
    tx_data = 1; tx_en = 1;
    tick();
    check("R9", "tx 1 floats", pad_oe, 1'b0);
    tx_data = 0; #1;
    check("R9", "tx 0 drives", pad_oe, 1'b1);
    check("R9", "tx 0 pad low", pad, 1'b0);
    tx_en = 0;
    tick();
  endtask

  task automatic t_input();
    wr_dir(0);
    ext_en = 1; ext_val = 0; #1;
    check("R10", "pad_oe 0 with wom 1", pad_oe, 1'b0);
    check("R10", "reads ext 0 with wom 1", rd_data, 1'b0);
    ext_val = 1; #1;
    check("R10", "reads ext 1 with wom 1", rd_data, 1'b1);
    wr_wom(0);
    check("R10", "pad_oe 0 with wom 0", pad_oe, 1'b0);
    ext_val = 0; #1;
    check("R10", "reads ext 0 with wom 0", rd_data, 1'b0);
    ext_en = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    rst_n = 1;
    tick();
    t_reset();
    t_port_out();
    t_take();
    t_shadow();
    t_release();
    t_busy_only();
    t_wom();
    t_input();
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 5000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
    end
    #2;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule